// File: doc/BRIEF.md
# Dual-Channel Phase and Period Meter

This block times two square waves that share a frequency. One free-running counter serves both channels. It advances once on each cycle in which a prescaler tick is present, so every count stands for one tick interval. A tick every cycle of a 500 kHz timebase, for example, gives 2 microseconds per count.

Each input is asynchronous. It passes through a synchronizer, and then a rising-edge detector. On every detected rising edge the block captures the counter value. It subtracts the previous capture of the same channel to give that channel's period. Channel B edges also update a phase count: the distance from the latest channel A capture to the channel B capture.

The counter uses its whole 16-bit range and rolls over freely. All subtraction is modulo 2^16, so an interval that crosses the rollover needs no correction. A validity flag tells the consumer when both channels have completed a full cycle.

Top module: `phase_period_meter`

## Requirements
- R1: While rstN is low, and in the cycle after it rises, periodA, periodB, meanPeriod and phaseCount are zero and measValid is low.
- R2: The 16-bit timebase counter advances by one only in cycles with tickEn high, so all results are in tick units. With one tick every four clocks, an input period of 40 clocks reads as 10.
- R3: On each rising edge of sigA, periodA becomes the number of ticks since the previous sigA rising edge. Between sigA edges it holds.
- R4: On each rising edge of sigB, periodB becomes the number of ticks since the previous sigB rising edge. Between sigB edges it holds.
- R5: meanPeriod equals (periodA + periodB) shifted right by one bit, with the sum formed one bit wider so it cannot overflow. Examples: 40 and 43 give 41; 50 and 51 give 50.
- R6: phaseCount changes only on sigB rising edges. It becomes the sigB capture minus the most recent sigA capture, modulo 2^16.
- R7: When both inputs show a rising edge in the same cycle, both channels are processed in that cycle, and phaseCount becomes 0.
- R8: measValid stays low until each channel has seen at least two rising edges since reset. It then stays high until the next reset.
- R9: A period or phase interval that spans the counter rollover from 0xFFFF to 0 is still reported as the true tick count.
- R10: Both inputs go through an identical two-flop synchronizer. With a tick every cycle, a sigB rise d clocks after a sigA rise reads as a phase of d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Prescaler tick; the timebase advances in cycles where it is high |
| sigA | input | 1 | Asynchronous square-wave input, channel A |
| sigB | input | 1 | Asynchronous square-wave input, channel B |
| periodA | output | 16 | Latest channel A period in ticks |
| periodB | output | 16 | Latest channel B period in ticks |
| meanPeriod | output | 16 | Floor of the average of the two periods |
| phaseCount | output | 16 | Ticks from the latest A capture to the latest B capture |
| measValid | output | 1 | Both channels have completed at least one full cycle |

## Verification
The hardest case to reach from the ports is a measurement interval that straddles the counter rollover. The counter is internal and needs 65,536 ticks to wrap. The bench therefore drives a continuous 3000-clock wave on both inputs, with a 700-clock offset, for more than 65,536 cycles, and it checks periods and phase after every wave period. Some of those intervals must cross the rollover, whatever the counter's starting value.

Coincident edges and the validity threshold are reached by exact cycle placement of the input rises. Validity is checked just before and just after the second edge of the slower channel.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
  // Capture strobes from the control unit to the datapath
  typedef struct packed {
    logic capA;
    logic capB;
  } ppm_strobe_t;

  localparam int unsigned NumChan = 2;
  localparam int unsigned ChanA   = 0;
  localparam int unsigned ChanB   = 1;
endpackage

// File: rtl/ppm_sync_edge.sv
module ppm_sync_edge #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] asyncIn,
  output logic [NUM_CH-1:0] riseOut
);
  // Stage indices: 0..STAGES-1 form the synchronizer, STAGES is the history flop
  localparam int unsigned LastSync = STAGES - 1;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [STAGES:0] shiftReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shiftReg <= '0;
      end else begin
        shiftReg <= {shiftReg[STAGES-1:0], asyncIn[ch]};
      end
    end

    assign riseOut[ch] = shiftReg[LastSync] & ~shiftReg[STAGES];

    // A rise needs a low sample in between, so it never lasts two cycles
    p_rise_single_r10: assert property (@(posedge clk) disable iff (!rstN)
      riseOut[ch] |=> !riseOut[ch]);
  end
endmodule

// File: rtl/ppm_ctrl.sv
module ppm_ctrl
  import ppm_pkg::*;
#(
  parameter int unsigned NUM_CH = NumChan
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] rise,
  output ppm_strobe_t       strobe,
  output logic              measValid
);
  // Two edges per channel make one full cycle
  localparam int unsigned EdgesNeeded = 2;
  localparam int unsigned EdgeCntW    = $clog2(EdgesNeeded + 1);

  logic [NUM_CH-1:0] chanReady;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_edges
    logic [EdgeCntW-1:0] edgeCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        edgeCnt <= '0;
      end else if (rise[ch] && (edgeCnt != EdgeCntW'(EdgesNeeded))) begin
        edgeCnt <= edgeCnt + 1'b1;
      end
    end

    assign chanReady[ch] = (edgeCnt == EdgeCntW'(EdgesNeeded));
  end

  // Both channels are serviced in the same cycle when their edges coincide
  always_comb begin
    strobe.capA = rise[ChanA];
    strobe.capB = rise[ChanB];
  end

  assign measValid = &chanReady;

  p_valid_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    measValid |=> measValid);

  p_valid_after_edge_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(measValid) |-> $past(strobe.capA || strobe.capB));

  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capA |=> !strobe.capA);
endmodule

// File: rtl/ppm_datapath.sv
module ppm_datapath
  import ppm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  ppm_strobe_t      strobe,
  output logic [CNT_W-1:0] periodA,
  output logic [CNT_W-1:0] periodB,
  output logic [CNT_W-1:0] meanPeriod,
  output logic [CNT_W-1:0] phaseCount
);
  localparam int unsigned SumW = CNT_W + 1;

  logic [CNT_W-1:0] timeBase;
  logic [CNT_W-1:0] lastCapA;
  logic [CNT_W-1:0] lastCapB;
  logic [CNT_W-1:0] latestA;
  logic [SumW-1:0]  periodSum;

  // Free-running timebase using the full range, so wrap is natural
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeBase <= '0;
    end else if (tickEn) begin
      timeBase <= timeBase + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastCapA <= '0;
      periodA  <= '0;
    end else if (strobe.capA) begin
      periodA  <= timeBase - lastCapA;
      lastCapA <= timeBase;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastCapB <= '0;
      periodB  <= '0;
    end else if (strobe.capB) begin
      periodB  <= timeBase - lastCapB;
      lastCapB <= timeBase;
    end
  end

  // A coincident A edge counts as the latest A capture
  assign latestA = strobe.capA ? timeBase : lastCapA;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCount <= '0;
    end else if (strobe.capB) begin
      phaseCount <= timeBase - latestA;
    end
  end

  assign periodSum  = {1'b0, periodA} + {1'b0, periodB};
  assign meanPeriod = periodSum[SumW-1:1];

  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(timeBase));

  p_per_a_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capA |=> $stable(periodA));

  p_per_b_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capB |=> $stable(periodB));

  p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capB |=> $stable(phaseCount));

  p_coincident_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capA && strobe.capB) |=> (phaseCount == '0));
endmodule

// File: rtl/phase_period_meter.sv
module phase_period_meter
  import ppm_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             sigA,
  input  logic             sigB,
  output logic [CNT_W-1:0] periodA,
  output logic [CNT_W-1:0] periodB,
  output logic [CNT_W-1:0] meanPeriod,
  output logic [CNT_W-1:0] phaseCount,
  output logic             measValid
);
  logic [NumChan-1:0] rawIn;
  logic [NumChan-1:0] riseVec;
  ppm_strobe_t        strobe;

  assign rawIn[ChanA] = sigA;
  assign rawIn[ChanB] = sigB;

  ppm_sync_edge #(
    .NUM_CH (NumChan),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (rawIn),
    .riseOut (riseVec)
  );

  ppm_ctrl #(
    .NUM_CH (NumChan)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rise      (riseVec),
    .strobe    (strobe),
    .measValid (measValid)
  );

  ppm_datapath #(
    .CNT_W (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .strobe     (strobe),
    .periodA    (periodA),
    .periodB    (periodB),
    .meanPeriod (meanPeriod),
    .phaseCount (phaseCount)
  );
endmodule

// File: tb/phase_period_meter_tb.sv
`timescale 1ns/1ps
module phase_period_meter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        sigA = 1'b0;
  logic        sigB = 1'b0;
  logic [15:0] periodA, periodB, meanPeriod, phaseCount;
  logic        measValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  phase_period_meter u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .sigA       (sigA),
    .sigB       (sigB),
    .periodA    (periodA),
    .periodB    (periodB),
    .meanPeriod (meanPeriod),
    .phaseCount (phaseCount),
    .measValid  (measValid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; sigA = 1'b0; sigB = 1'b0; tickEn = 1'b0;
    idle(3);
    rstN = 1'b1;
  endtask

  // Drives both waves; A rises when cyc%pa==0, B rises when (cyc-off)%pb==0
  task automatic runWave(input int startCyc, input int nCyc, input int pa,
                         input int pb, input int off, input int div);
    for (int c = startCyc; c < startCyc + nCyc; c++) begin
      @(negedge clk);
      sigA   = (c % pa) < (pa / 2);
      sigB   = (c >= off) && (((c - off) % pb) < (pb / 2));
      tickEn = (c % div) == 0;
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    rstN = 1'b0; sigA = 1'b1; sigB = 1'b1; tickEn = 1'b1;
    idle(2);
    chk("R1 periodA in reset", periodA, 0);
    chk("R1 valid in reset", measValid, 0);
    rstN = 1'b1; sigA = 1'b0; sigB = 1'b0;
    idle(1);
    chk("R1 periodB after reset", periodB, 0);
    chk("R1 mean after reset", meanPeriod, 0);
    chk("R1 phase after reset", phaseCount, 0);
  endtask

  task automatic testValid();
    doReset();
    runWave(0, 21, 20, 20, 5, 1);
    idle(6);
    chk("R8 valid low with one B edge", measValid, 0);
    chk("R3 periodA 20", periodA, 20);
    runWave(21, 6, 20, 20, 5, 1);
    idle(6);
    chk("R8 valid after second B edge", measValid, 1);
    idle(20);
    chk("R8 valid stays high", measValid, 1);
  endtask

  task automatic testSteady();
    doReset();
    runWave(0, 200, 30, 30, 7, 1);
    chk("R3 periodA 30", periodA, 30);
    chk("R4 periodB 30", periodB, 30);
    chk("R6 phase 7", phaseCount, 7);
    chk("R10 equal sync latency", phaseCount, 7);
    doReset();
    runWave(0, 200, 30, 30, 29, 1);
    chk("R6 phase 29", phaseCount, 29);
  endtask

  task automatic testCoincident();
    doReset();
    runWave(0, 200, 30, 30, 0, 1);
    chk("R7 phase zero", phaseCount, 0);
    chk("R7 periodA", periodA, 30);
    chk("R7 periodB", periodB, 30);
  endtask

  task automatic testPrescale();
    doReset();
    runWave(0, 400, 40, 40, 16, 4);
    chk("R2 periodA ticks", periodA, 10);
    chk("R2 periodB ticks", periodB, 10);
    chk("R2 phase ticks", phaseCount, 4);
  endtask

  task automatic testMean();
    doReset();
    runWave(0, 400, 40, 43, 3, 1);
    chk("R4 periodB 43", periodB, 43);
    chk("R5 mean 40/43", meanPeriod, 41);
    doReset();
    runWave(0, 400, 50, 51, 3, 1);
    chk("R5 mean 50/51", meanPeriod, 50);
  endtask

  task automatic testWrap();
    doReset();
    for (int k = 0; k < 25; k++) begin
      runWave(k * 3000, 3000, 3000, 3000, 700, 1);
      if (k >= 2) begin
        chk("R9 periodA across wrap", periodA, 3000);
        chk("R9 periodB across wrap", periodB, 3000);
        chk("R9 phase across wrap", phaseCount, 700);
      end
    end
  endtask

  initial begin
    testReset();
    testValid();
    testSteady();
    testCoincident();
    testPrescale();
    testMean();
    testWrap();
    idle(2);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule